// File: doc/BRIEF.md
# Interleaved Four-Bank Line Refill Controller

This block fills a cache line from four memory banks that are each one word (64 bits) wide. Words are spread across the banks by the low two bits of the word address, so the four words of an aligned 32-byte line live in banks 0, 1, 2 and 3 at the same row. For each line request the controller spends a fixed address phase, then starts the banks, waits for their read data, and returns the four words one at a time on a one-word response stream.

In the default interleaved variant all four banks are started in the same cycle, so their access times overlap and only the word transfers are serialized. A line then costs 4 + 56 + 4×4 = 76 cycles. With the `INTERLEAVE` parameter at 0 the controller runs each word as a full address/access/transfer sequence against a single bank, which costs 4 × (4 + 56 + 4) = 256 cycles. This serial form is kept as a baseline for comparison. The bank models, with their fixed access latency, sit outside the block.

Requests use a valid/ready handshake and only one line can be in flight. `req_ready` stays low from acceptance until the fourth word has been handed over. Responses also use valid/ready. When the consumer holds `rsp_ready` low, the current word is held stable and the next word's transfer slot does not start until the handshake completes.

Top module: `interleaved_refill_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid`, `rsp_last` and all `bank_en` bits are 0.
- R2: The k-th word returned for a line (k = 0..3) is the data that bank k returns for that line's row. Words come back in bank order 0, 1, 2, 3.
- R3: In the interleaved variant, `bank_en` is 4'b1111 for exactly one cycle per line. In the serial variant it is one-hot with bit k set for exactly one cycle before word k, which gives four pulses per line in ascending order. `bank_en` is 0 whenever the controller is idle.
- R4: `bank_row` equals `req_addr[31:5]` of the accepted request. Address bits 4:0 have no effect on the row or on the returned data.
- R5: In the interleaved variant, with `rsp_ready` held high, the first word is valid 63 cycles after the accepting clock edge and consecutive words are 4 cycles apart. This puts the last word in cycle 75, for 76 cycles per line.
- R6: In the serial variant, with `rsp_ready` held high, each word is valid 63 cycles after the previous handshake (or after acceptance), for 256 cycles per line.
- R7: `rsp_last` is 1 only together with `rsp_valid` on the fourth word of a line.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_data` and `rsp_last` stay unchanged. The next word's slot begins only after the handshake.
- R9: `req_ready` goes low in the cycle after a request is accepted and stays low until after the fourth word's handshake. A request held during that time is accepted only afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Line request valid |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_addr | input | 32 | Byte address of the line; bits 4:0 ignored |
| rsp_valid | output | 1 | Response word valid |
| rsp_ready | input | 1 | Consumer accepts the response word |
| rsp_data | output | 64 | Response word |
| rsp_last | output | 1 | Marks the fourth word of the line |
| bank_en | output | 4 | Per-bank read start pulse |
| bank_row | output | 27 | Row (line index) presented to the banks |
| bank_rdata | input | 256 | Read data, bank k on bits 64k+63:64k |
| bank_rvalid | input | 4 | Per-bank read data valid pulse |

## Verification
The assertions assume the banks behave like fixed-latency memories. Each bank raises `bank_rvalid` once, a fixed number of cycles after its enable, and never without a prior enable. The properties also rely on the consumer using the handshake as specified. The bench meets these assumptions by building its bank models with a single countdown per bank that starts only on `bank_en`. Its consumer only varies `rsp_ready`. It also deliberately holds `req_valid` high during a busy line, so the single-outstanding rule is exercised at the edge of its assumption.

// File: rtl/ilv_refill_pkg.sv
package ilv_refill_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ISSUE,
    S_WAIT,
    S_XFER
  } seq_state_e;
endpackage

// File: rtl/ilv_refill_seq.sv
module ilv_refill_seq
  import ilv_refill_pkg::*;
#(
  parameter int NB         = 4,
  parameter int ADDR_CYC   = 4,
  parameter int XFER_CYC   = 4,
  parameter bit INTERLEAVE = 1'b1,
  localparam int IDX_W     = $clog2(NB),
  localparam int MAXC      = (ADDR_CYC > XFER_CYC) ? ADDR_CYC : XFER_CYC,
  localparam int CNT_W     = $clog2(MAXC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             rsp_ready,
  input  logic [NB-1:0]    bank_rvalid,
  output logic             idle,
  output logic [IDX_W-1:0] beat,
  output logic [NB-1:0]    bank_en,
  output logic [NB-1:0]    capture,
  output logic             rsp_valid,
  output logic             rsp_last
);
  seq_state_e          state;
  logic [CNT_W-1:0]    cnt;
  logic [NB-1:0]       pending;
  logic [NB-1:0]       issue_mask;
  logic [NB-1:0]       still_open;

  generate
    if (INTERLEAVE) begin : g_all_banks
      assign issue_mask = {NB{1'b1}};
    end else begin : g_one_bank
      assign issue_mask = NB'(1) << beat;
    end
  endgenerate

  assign still_open = pending & ~bank_rvalid;
  assign idle       = (state == S_IDLE);
  assign bank_en    = (state == S_ISSUE) ? issue_mask : '0;
  assign capture    = (state == S_WAIT) ? (pending & bank_rvalid) : '0;
  assign rsp_valid  = (state == S_XFER) && (cnt == '0);
  assign rsp_last   = rsp_valid && (beat == IDX_W'(NB - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      beat    <= '0;
      pending <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (req_fire) begin
          state <= S_ADDR;
          cnt   <= CNT_W'(ADDR_CYC - 1);
          beat  <= '0;
        end
        S_ADDR: if (cnt == '0) state <= S_ISSUE;
                else           cnt   <= cnt - 1'b1;
        S_ISSUE: begin
          pending <= issue_mask;
          state   <= S_WAIT;
        end
        S_WAIT: begin
          pending <= still_open;
          if (still_open == '0) begin
            state <= S_XFER;
            cnt   <= CNT_W'(XFER_CYC - 1);
          end
        end
        S_XFER: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (rsp_ready) begin
            if (beat == IDX_W'(NB - 1)) begin
              state <= S_IDLE;
            end else begin
              beat <= beat + 1'b1;
              if (INTERLEAVE) begin
                cnt <= CNT_W'(XFER_CYC - 1);
              end else begin
                state <= S_ADDR;
                cnt   <= CNT_W'(ADDR_CYC - 1);
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ilv_line_buf.sv
module ilv_line_buf #(
  parameter int NB     = 4,
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(NB)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NB-1:0]      capture,
  input  logic [NB*DATA_W-1:0] bank_rdata,
  input  logic [IDX_W-1:0]   sel,
  output logic [DATA_W-1:0]  word_out
);
  logic [DATA_W-1:0] words [NB];

  for (genvar b = 0; b < NB; b++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)          words[b] <= '0;
      else if (capture[b]) words[b] <= bank_rdata[b*DATA_W +: DATA_W];
    end
  end

  assign word_out = words[sel];
endmodule

// File: rtl/interleaved_refill_ctrl.sv
module interleaved_refill_ctrl #(
  parameter int NB         = 4,
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 32,
  parameter int ADDR_CYC   = 4,
  parameter int XFER_CYC   = 4,
  parameter bit INTERLEAVE = 1'b1,
  localparam int IDX_W     = $clog2(NB),
  localparam int OFF_W     = $clog2(NB * DATA_W / 8),
  localparam int ROW_W     = ADDR_W - OFF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_data,
  output logic                 rsp_last,
  output logic [NB-1:0]        bank_en,
  output logic [ROW_W-1:0]     bank_row,
  input  logic [NB*DATA_W-1:0] bank_rdata,
  input  logic [NB-1:0]        bank_rvalid
);
  logic             req_fire;
  logic [IDX_W-1:0] beat;
  logic [NB-1:0]    capture;
  logic [ROW_W-1:0] row_q;
  logic             unused_offset;

  assign unused_offset = ^req_addr[OFF_W-1:0];
  assign req_fire      = req_valid && req_ready;
  assign bank_row      = row_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        row_q <= '0;
    else if (req_fire) row_q <= req_addr[ADDR_W-1:OFF_W];
  end

  ilv_refill_seq #(
    .NB(NB), .ADDR_CYC(ADDR_CYC), .XFER_CYC(XFER_CYC), .INTERLEAVE(INTERLEAVE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .rsp_ready(rsp_ready),
    .bank_rvalid(bank_rvalid), .idle(req_ready), .beat(beat), .bank_en(bank_en),
    .capture(capture), .rsp_valid(rsp_valid), .rsp_last(rsp_last)
  );

  ilv_line_buf #(.NB(NB), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .capture(capture), .bank_rdata(bank_rdata),
    .sel(beat), .word_out(rsp_data)
  );
endmodule

// File: rtl/ilv_refill_chk.sv
module ilv_refill_chk #(
  parameter int NB     = 4,
  parameter int DATA_W = 64,
  parameter bit ILV    = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_last,
  input logic [NB-1:0]     bank_en
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_last)));

  assert_accept_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_busy_while_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_last_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid);

  assert_enable_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_en != '0) |-> (ILV ? (bank_en == {NB{1'b1}}) : ($countones(bank_en) == 1)));

  assert_enable_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_en != '0) |=> (bank_en == '0));

  assert_idle_no_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bank_en == '0));
endmodule

bind interleaved_refill_ctrl ilv_refill_chk #(
  .NB(NB), .DATA_W(DATA_W), .ILV(INTERLEAVE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .rsp_last(rsp_last), .bank_en(bank_en)
);

// File: tb/interleaved_refill_ctrl_test.sv
package ilv_tb_pkg;
  function automatic logic [63:0] word_pat(input int b, input logic [26:0] row);
    return {8'hB0 + 8'(b), 5'd0, row, 24'hC3A500 ^ row[23:0]};
  endfunction
endpackage

module ilv_bank_model
  import ilv_tb_pkg::*;
#(
  parameter int NB  = 4,
  parameter int ACC = 56
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] en,
  input  logic [26:0]   row,
  output logic [NB*64-1:0] rdata,
  output logic [NB-1:0] rvalid
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    int          rem;
    logic [26:0] rq;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rem <= 0; rvalid[b] <= 1'b0; rq <= '0;
      end else begin
        rvalid[b] <= 1'b0;
        if (en[b]) begin
          rem <= ACC - 2; rq <= row;
        end else if (rem == 1) begin
          rvalid[b] <= 1'b1; rem <= 0;
        end else if (rem > 1) begin
          rem <= rem - 1;
        end
      end
    end
    assign rdata[b*64 +: 64] = word_pat(b, rq);
  end
endmodule

module interleaved_refill_ctrl_test;
  import ilv_tb_pkg::*;

  localparam int ADDR_CYC  = 4;
  localparam int ACC       = 56;
  localparam int XFER      = 4;
  localparam int FIRST     = ADDR_CYC + ACC + XFER - 1;
  localparam int LINE_ILV  = ADDR_CYC + ACC + 4 * XFER;
  localparam int LINE_FLAT = 4 * (ADDR_CYC + ACC + XFER);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]   req_valid = '0;
  logic [1:0]   rsp_ready = '1;
  logic [31:0]  req_addr [2];
  logic [1:0]   req_ready, rsp_valid, rsp_last;
  logic [63:0]  rsp_data [2];
  logic [3:0]   bank_en [2];
  logic [26:0]  bank_row [2];
  logic [255:0] bank_rdata [2];
  logic [3:0]   bank_rvalid [2];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit          act [2];
  int          cnt [2], beat [2], lat [2], en_cnt [2];
  logic [26:0] mrow [2];
  bit          bp [2];

  initial begin
    req_addr[0] = '0; req_addr[1] = '0;
    for (int L = 0; L < 2; L++) begin
      act[L] = 0; cnt[L] = 0; beat[L] = 0; lat[L] = 0; en_cnt[L] = 0; mrow[L] = '0; bp[L] = 0;
    end
  end

  interleaved_refill_ctrl #(.ADDR_CYC(ADDR_CYC), .XFER_CYC(XFER), .INTERLEAVE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_ready(req_ready[0]),
    .req_addr(req_addr[0]), .rsp_valid(rsp_valid[0]), .rsp_ready(rsp_ready[0]),
    .rsp_data(rsp_data[0]), .rsp_last(rsp_last[0]), .bank_en(bank_en[0]),
    .bank_row(bank_row[0]), .bank_rdata(bank_rdata[0]), .bank_rvalid(bank_rvalid[0])
  );

  interleaved_refill_ctrl #(.ADDR_CYC(ADDR_CYC), .XFER_CYC(XFER), .INTERLEAVE(1'b0)) uut_flat (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_ready(req_ready[1]),
    .req_addr(req_addr[1]), .rsp_valid(rsp_valid[1]), .rsp_ready(rsp_ready[1]),
    .rsp_data(rsp_data[1]), .rsp_last(rsp_last[1]), .bank_en(bank_en[1]),
    .bank_row(bank_row[1]), .bank_rdata(bank_rdata[1]), .bank_rvalid(bank_rvalid[1])
  );

  ilv_bank_model #(.ACC(ACC)) bk0 (.clk(clk), .rst_n(rst_n), .en(bank_en[0]),
    .row(bank_row[0]), .rdata(bank_rdata[0]), .rvalid(bank_rvalid[0]));
  ilv_bank_model #(.ACC(ACC)) bk1 (.clk(clk), .rst_n(rst_n), .en(bank_en[1]),
    .row(bank_row[1]), .rdata(bank_rdata[1]), .rvalid(bank_rvalid[1]));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] actual, input logic [63:0] expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, actual, expected, $time);
    end
  endtask

  // Behavioural reference, one lane per instance; compared every cycle.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int L = 0; L < 2; L++) begin
        bit    ev;
        string tlat;
        tlat = (L == 0) ? "R5" : "R6";
        ev = act[L] && (cnt[L] == 0);
        check(req_ready[L] == !act[L], "R9", "req_ready", 64'(req_ready[L]), 64'(!act[L]));
        check(rsp_valid[L] == ev, tlat, "rsp_valid timing", 64'(rsp_valid[L]), 64'(ev));
        if (ev) begin
          check(rsp_data[L] == word_pat(beat[L], mrow[L]), "R2", "word data",
                rsp_data[L], word_pat(beat[L], mrow[L]));
          check(rsp_last[L] == (beat[L] == 3), "R7", "rsp_last on beat",
                64'(rsp_last[L]), 64'(beat[L] == 3));
          if (!rsp_ready[L]) bp[L] = 1;
        end else begin
          check(rsp_last[L] == 1'b0, "R7", "rsp_last without word", 64'(rsp_last[L]), 64'd0);
        end
        if (bank_en[L] != '0) begin
          logic [3:0] exp_en;
          exp_en = (L == 0) ? 4'hF : 4'(1 << beat[L]);
          en_cnt[L]++;
          check(bank_en[L] == exp_en, "R3", "bank_en pattern", 64'(bank_en[L]), 64'(exp_en));
          check(bank_row[L] == mrow[L], "R4", "bank_row", 64'(bank_row[L]), 64'(mrow[L]));
        end
        if (!act[L]) begin
          if (req_valid[L]) begin
            act[L] = 1; cnt[L] = FIRST; beat[L] = 0; lat[L] = 0; bp[L] = 0; en_cnt[L] = 0;
            mrow[L] = req_addr[L][31:5];
          end
        end else begin
          if (ev && rsp_ready[L] && beat[L] == 3) begin
            if (!bp[L])
              check(lat[L] + 1 == ((L == 0) ? LINE_ILV : LINE_FLAT), tlat, "line latency",
                    64'(lat[L] + 1), 64'((L == 0) ? LINE_ILV : LINE_FLAT));
            check(en_cnt[L] == ((L == 0) ? 1 : 4), "R3", "enable pulses per line",
                  64'(en_cnt[L]), 64'((L == 0) ? 1 : 4));
            act[L] = 0;
          end else if (cnt[L] > 0) begin
            cnt[L]--;
          end else if (rsp_ready[L]) begin
            beat[L]++;
            cnt[L] = (L == 0) ? XFER - 1 : FIRST;
          end
          lat[L]++;
        end
      end
    end
  end

  task automatic send(input int L, input logic [31:0] a);
    bit taken;
    taken = 0;
    @(posedge clk); #2;
    req_valid[L] = 1'b1; req_addr[L] = a;
    while (!taken) begin
      @(negedge clk);
      if (req_ready[L]) taken = 1;
    end
    @(posedge clk); #2;
    req_valid[L] = 1'b0;
  endtask

  task automatic wait_idle(input int L);
    do @(posedge clk); while (act[L] || req_valid[L]);
  endtask

  task automatic ready_pattern(input int L, input int period, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #3;
      rsp_ready[L] = ((i % period) == period - 1);
    end
    @(posedge clk); #3;
    rsp_ready[L] = 1'b1;
  endtask

  task automatic finish_up();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    finish_up();
  end

  initial begin
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    for (int L = 0; L < 2; L++) begin
      check(req_ready[L] == 1'b1, "R1", "req_ready after reset", 64'(req_ready[L]), 64'd1);
      check(rsp_valid[L] == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid[L]), 64'd0);
      check(rsp_last[L] == 1'b0, "R1", "rsp_last after reset", 64'(rsp_last[L]), 64'd0);
      check(bank_en[L] == 4'h0, "R1", "bank_en after reset", 64'(bank_en[L]), 64'd0);
    end
    // Plain lines, R4 low address bits set on the second one.
    fork
      begin send(0, 32'h0000_0040); wait_idle(0); send(0, 32'h0000_007F); wait_idle(0); end
      begin send(1, 32'h0001_2340); wait_idle(1); send(1, 32'h0001_235B); wait_idle(1); end
    join
    // R8 back-pressure with different consumer rates.
    fork
      begin fork send(0, 32'h0000_00A0); ready_pattern(0, 3, 300); join wait_idle(0); end
      begin fork send(1, 32'h00AB_CDE0); ready_pattern(1, 5, 600); join wait_idle(1); end
    join
    // R9 second request raised while a line is still in flight.
    fork
      begin send(0, 32'h0000_0100); send(0, 32'h0000_013F); wait_idle(0); end
      begin send(1, 32'h0000_0200); send(1, 32'h0000_0221); wait_idle(1); end
    join
    repeat (4) @(posedge clk);
    finish_up();
  end
endmodule